// File: doc/BRIEF.md
# SONET/SDH Serial Frame Aligner

This block sits behind a 1:8 deserialiser front end and takes one NRZ bit per serial clock. It watches the raw bit stream for the SONET/SDH framing word: a run of A1 bytes followed directly by a run of A2 bytes. When it sees the word, it moves its byte boundary to that point. From then on it delivers whole bytes on an 8-bit bus with a one-cycle byte strobe. A one-byte frame marker accompanies the last A2 byte.

The search is controlled by a level-sensitive out-of-frame input. While that input is high, every occurrence of the framing word realigns the byte boundary and raises the frame marker, even when the block is already locked. While it is low, the byte counter keeps the boundary it last had and no marker is produced. The framing word is built from parameters. By default it is three A1 bytes of 0xF6 followed by three A2 bytes of 0x28.

Top module: `sonet_frame_aligner`

## Requirements
- R1: A frame is detected only when the most recent 48 serial bits equal 0xF6F6F6282828, taken first bit first, at any bit offset. A stream that has fewer A1 bytes before the A2 bytes produces no frame marker.
- R2: After a detection, `byte_en` is high with `rx_byte` = 0x28 one serial clock after the last framing bit is sampled. Further bytes follow every 8 serial clocks on the new boundary.
- R3: `frame_pulse` is high for exactly one serial clock, only together with `byte_en`, and only while `rx_byte` shows the final A2 byte (0x28).
- R4: While `oof` is high, each detected frame moves the byte boundary again, even if the block was already aligned at another offset.
- R5: While `oof` is low, a framing word in the stream raises no `frame_pulse` and leaves the byte boundary unchanged.
- R6: A detection that completes in the first serial clock after `oof` falls still realigns and raises `frame_pulse`. A detection that completes one clock later does neither.
- R7: The first bit received in a byte lands in `rx_byte[7]` and the last in `rx_byte[0]`.
- R8: While `rst` is high at a clock edge, the outputs become zero and the byte counter restarts. After `rst` is released, the first `byte_en` comes in the 8th serial clock.
- R9: Between realignments, `byte_en` comes exactly once every 8 serial clocks, and `rx_byte` holds its value between strobes.
- R10: Raising `oof` 32 serial clocks (4 byte times) before the A1-to-A2 boundary is enough for that frame to be recovered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sdin | input | 1 | Serial NRZ data, one bit per clock |
| oof | input | 1 | Out-of-frame level; high enables the search and realignment |
| rx_byte | output | 8 | Byte-aligned parallel data, first received bit in bit 7 |
| byte_en | output | 1 | One-clock strobe marking a new `rx_byte` |
| frame_pulse | output | 1 | One-clock frame marker on the final A2 byte |

## Verification
A wrong shift-window compare or bit order shows up at once: the byte strobed together with the frame marker is not 0x28, or the payload bytes that follow are bit-rotated, within 8 to 16 clocks of the framing word. A byte counter that restarts at the wrong value, or that drifts, breaks the fixed 8-clock spacing of `byte_en` at the next strobe. A faulty out-of-frame gate shows as a missing marker or a stray marker, and as a boundary that moves when it should stay. In both cases the move is visible at the first strobe after the framing word. The framing word is placed at all eight bit offsets in turn, so every counter phase goes through a realignment.

// File: rtl/frm_pkg.sv
package frm_pkg;

    localparam int unsigned FRM_BYTE_W = 8;
    localparam int unsigned FRM_CNT_W  = $clog2(FRM_BYTE_W);

    localparam logic [FRM_BYTE_W-1:0] FRM_A1_DEFAULT = 8'hF6;
    localparam logic [FRM_BYTE_W-1:0] FRM_A2_DEFAULT = 8'h28;

    // Byte-counter action chosen each serial clock
    typedef enum logic {
        CNT_ADVANCE = 1'b0,
        CNT_RESTART = 1'b1
    } cnt_action_e;

    // One beat on the parallel side
    typedef struct packed {
        logic [FRM_BYTE_W-1:0] data;
        logic                  en;
        logic                  fp;
    } rx_beat_t;

endpackage

// File: rtl/frm_pattern_match.sv
module frm_pattern_match
    import frm_pkg::*;
#(
    parameter int unsigned           N_A1   = 3,
    parameter int unsigned           N_A2   = 3,
    parameter logic [FRM_BYTE_W-1:0] A1_VAL = FRM_A1_DEFAULT,
    parameter logic [FRM_BYTE_W-1:0] A2_VAL = FRM_A2_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sdin,
    output logic [FRM_BYTE_W-1:0] win_byte,
    output logic                  hit
);
    localparam int unsigned N_BYTES = N_A1 + N_A2;
    localparam int unsigned PAT_W   = N_BYTES * FRM_BYTE_W;

    logic [PAT_W-1:0] window;
    logic [PAT_W-1:0] pattern;

    // Framing word assembled byte by byte, oldest byte in the top slice
    for (genvar g = 0; g < N_BYTES; g++) begin : g_pat
        if (g < N_A1) begin : g_a1
            assign pattern[PAT_W-1-g*FRM_BYTE_W -: FRM_BYTE_W] = A1_VAL;
        end else begin : g_a2
            assign pattern[PAT_W-1-g*FRM_BYTE_W -: FRM_BYTE_W] = A2_VAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            window <= '0;
        end else begin
            window <= {window[PAT_W-2:0], sdin};
        end
    end

    assign hit      = (window == pattern);
    assign win_byte = window[FRM_BYTE_W-1:0];

endmodule

// File: rtl/frm_oof_gate.sv
module frm_oof_gate (
    input  logic clk,
    input  logic rst,
    input  logic oof,
    input  logic hit,
    output logic accept
);
    logic oof_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            oof_prev <= 1'b0;
        end else begin
            oof_prev <= oof;
        end
    end

    // A match is honoured while oof is high or in the clock right after it fell
    assign accept = hit & (oof | oof_prev);

endmodule

// File: rtl/frm_byte_timer.sv
module frm_byte_timer
    import frm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic load
);
    localparam logic [FRM_CNT_W-1:0] LAST = FRM_CNT_W'(FRM_BYTE_W - 1);

    logic [FRM_CNT_W-1:0] cnt;
    cnt_action_e          action;

    assign action = restart ? CNT_RESTART : CNT_ADVANCE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case (action)
                CNT_RESTART: cnt <= '0;
                CNT_ADVANCE: cnt <= cnt + 1'b1;
                default:     cnt <= '0;
            endcase
        end
    end

    assign load = (cnt == LAST) | restart;

endmodule

// File: rtl/frm_out_stage.sv
module frm_out_stage
    import frm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  is_frame,
    input  logic [FRM_BYTE_W-1:0] win_byte,
    output rx_beat_t              beat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.en <= load;
            beat.fp <= is_frame;
            if (load) begin
                beat.data <= win_byte;
            end
        end
    end

endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner
    import frm_pkg::*;
#(
    parameter int unsigned           N_A1   = 3,
    parameter int unsigned           N_A2   = 3,
    parameter logic [FRM_BYTE_W-1:0] A1_VAL = FRM_A1_DEFAULT,
    parameter logic [FRM_BYTE_W-1:0] A2_VAL = FRM_A2_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sdin,
    input  logic                  oof,
    output logic [FRM_BYTE_W-1:0] rx_byte,
    output logic                  byte_en,
    output logic                  frame_pulse
);
    logic [FRM_BYTE_W-1:0] win_byte;
    logic                  hit;
    logic                  accept;
    logic                  load;
    rx_beat_t              beat;

    frm_pattern_match #(
        .N_A1  (N_A1),
        .N_A2  (N_A2),
        .A1_VAL(A1_VAL),
        .A2_VAL(A2_VAL)
    ) u_match (
        .clk     (clk),
        .rst     (rst),
        .sdin    (sdin),
        .win_byte(win_byte),
        .hit     (hit)
    );

    frm_oof_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .oof   (oof),
        .hit   (hit),
        .accept(accept)
    );

    frm_byte_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(accept),
        .load   (load)
    );

    frm_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .is_frame(accept),
        .win_byte(win_byte),
        .beat    (beat)
    );

    assign rx_byte     = beat.data;
    assign byte_en     = beat.en;
    assign frame_pulse = beat.fp;

endmodule

// File: rtl/sonet_frame_aligner_checker.sv
module sonet_frame_aligner_checker
    import frm_pkg::*;
#(
    parameter logic [FRM_BYTE_W-1:0] A2_VAL = FRM_A2_DEFAULT
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  oof,
    input logic [FRM_BYTE_W-1:0] rx_byte,
    input logic                  byte_en,
    input logic                  frame_pulse
);
    p_pulse_with_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> byte_en);

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |=> !frame_pulse);

    p_pulse_on_a2_r2: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> (rx_byte == A2_VAL));

    p_pulse_needs_oof_r6: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> ($past(oof) || $past(oof, 2)));

    p_strobe_spacing_r9: assert property (@(posedge clk) disable iff (rst)
        byte_en |=> (!byte_en || frame_pulse));

    p_data_held_r9: assert property (@(posedge clk) disable iff (rst)
        !byte_en |-> $stable(rx_byte));

endmodule

bind sonet_frame_aligner sonet_frame_aligner_checker #(
    .A2_VAL(A2_VAL)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .oof        (oof),
    .rx_byte    (rx_byte),
    .byte_en    (byte_en),
    .frame_pulse(frame_pulse)
);

// File: tb/tb_sonet_frame_aligner.sv
module tb_sonet_frame_aligner;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_STEPS  = 32768;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sdin = 1'b0;
    logic       oof = 1'b0;
    logic [7:0] rx_byte;
    logic       byte_en;
    logic       frame_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int steps    = 0;
    int last_en  = 0;
    int fp_total = 0;
    bit done     = 1'b0;

    bit       en_at [MAX_STEPS];
    bit       fp_at [MAX_STEPS];
    bit [7:0] dat_at[MAX_STEPS];

    sonet_frame_aligner dut (
        .clk        (clk),
        .rst        (rst),
        .sdin       (sdin),
        .oof        (oof),
        .rx_byte    (rx_byte),
        .byte_en    (byte_en),
        .frame_pulse(frame_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one serial bit and the oof level, then sample after the edge
    task automatic step(input bit b, input bit o);
        sdin = b;
        oof  = o;
        @(posedge clk);
        @(negedge clk);
        steps++;
        en_at[steps]  = byte_en;
        fp_at[steps]  = frame_pulse;
        dat_at[steps] = rx_byte;
        if (frame_pulse) fp_total++;
        if (byte_en && !rst) begin
            // R9: fixed 8-clock strobe spacing unless this strobe is a realignment
            if (last_en > 0 && !frame_pulse)
                chk(steps - last_en == 8, "R9 strobe spacing", steps - last_en, 8);
            last_en = steps;
        end
    endtask

    // R7: first bit sent lands in bit 7
    task automatic send_byte(input bit [7:0] v, input bit o);
        for (int i = 7; i >= 0; i--) step(v[i], o);
    endtask

    task automatic rand_fill(input int n, input bit o);
        for (int k = 0; k < n; k++) begin
            bit [7:0] v;
            v = 8'($urandom);
            if (v == 8'hF6) v = 8'h00;
            send_byte(v, o);
        end
    endtask

    // drop_last: last framing bit is driven with oof low
    task automatic send_pattern(input bit o, input bit drop_last);
        bit [47:0] p;
        p = 48'hF6F6F6282828;
        for (int i = 47; i >= 0; i--) step(p[i], (drop_last && i == 0) ? 1'b0 : o);
    endtask

    task automatic lock_test(input int off);
        int s;
        int f0;
        bit [7:0] p0;
        bit [7:0] p1;
        rand_fill(5, 1'b1);
        for (int k = 0; k < off; k++) step(1'($urandom), 1'b1);
        send_pattern(1'b1, 1'b0);
        s  = steps;
        f0 = fp_total;
        p0 = 8'($urandom);
        p1 = 8'($urandom);
        send_byte(p0, 1'b1);
        send_byte(p1, 1'b1);
        send_byte(8'h00, 1'b1);
        chk(fp_at[s+1] && en_at[s+1], "R3 marker with strobe", {fp_at[s+1], en_at[s+1]}, 3);
        chk(dat_at[s+1] == 8'h28, "R2 aligned byte is A2", dat_at[s+1], 8'h28);
        chk(!fp_at[s+2], "R3 marker one clock", fp_at[s+2], 0);
        chk(en_at[s+9] && dat_at[s+9] == p0, "R7 R4 first payload byte", dat_at[s+9], p0);
        chk(en_at[s+17] && dat_at[s+17] == p1, "R2 second payload byte", dat_at[s+17], p1);
        chk(fp_total - f0 == 1, "R1 one detection", fp_total - f0, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);

        // R8: reset state
        repeat (4) step(1'b1, 1'b1);
        chk(!byte_en && !frame_pulse && rx_byte == 8'h00, "R8 reset outputs",
            {rx_byte, byte_en, frame_pulse}, 0);
        rst = 1'b0;
        steps = 0;
        last_en = 0;
        repeat (16) step(1'b0, 1'b0);
        for (int k = 1; k < 8; k++)
            chk(!en_at[k], "R8 no early strobe", en_at[k], 0);
        chk(en_at[8], "R8 first strobe in clock 8", en_at[8], 1);
        chk(en_at[16] && !en_at[12], "R9 strobe period", {en_at[16], en_at[12]}, 2);

        // R1 R2 R3 R4 R7: framing word at every bit offset, oof held high
        for (int off = 0; off < 8; off++) lock_test(off);

        // R1: only two A1 bytes before the A2 run
        begin
            int f0;
            rand_fill(5, 1'b1);
            f0 = fp_total;
            send_byte(8'hF6, 1'b1); send_byte(8'hF6, 1'b1);
            send_byte(8'h28, 1'b1); send_byte(8'h28, 1'b1); send_byte(8'h28, 1'b1);
            send_byte(8'h00, 1'b1);
            chk(fp_total == f0, "R1 short A1 run ignored", fp_total - f0, 0);
        end

        // R5: oof low, framing word off the current boundary
        begin
            int s;
            int f0;
            rand_fill(5, 1'b0);
            repeat (3) step(1'($urandom), 1'b0);
            f0 = fp_total;
            send_pattern(1'b0, 1'b0);
            s = steps;
            send_byte(8'hA5, 1'b0);
            send_byte(8'h00, 1'b0);
            chk(fp_total == f0, "R5 no marker with oof low", fp_total - f0, 0);
            chk(!en_at[s+1], "R5 boundary kept", en_at[s+1], 0);
        end

        // R6: oof falls right after the last framing bit
        begin
            int s;
            rand_fill(5, 1'b1);
            repeat (5) step(1'($urandom), 1'b1);
            send_pattern(1'b1, 1'b0);
            s = steps;
            send_byte(8'h3C, 1'b0);
            send_byte(8'h00, 1'b0);
            chk(fp_at[s+1] && dat_at[s+1] == 8'h28, "R6 late fall honoured", fp_at[s+1], 1);
            chk(en_at[s+9] && dat_at[s+9] == 8'h3C, "R6 realigned payload", dat_at[s+9], 8'h3C);
        end

        // R6: oof already low on the last framing bit
        begin
            int f0;
            rand_fill(5, 1'b1);
            repeat (6) step(1'($urandom), 1'b1);
            f0 = fp_total;
            send_pattern(1'b1, 1'b1);
            send_byte(8'h00, 1'b0);
            send_byte(8'h00, 1'b0);
            chk(fp_total == f0, "R6 early fall not honoured", fp_total - f0, 0);
        end

        // R10: oof raised 32 clocks before the A1/A2 boundary
        begin
            int s;
            rand_fill(4, 1'b0);
            repeat (2) step(1'($urandom), 1'b0);
            rand_fill(1, 1'b1);
            send_pattern(1'b1, 1'b0);
            s = steps;
            send_byte(8'h81, 1'b1);
            send_byte(8'h00, 1'b1);
            chk(fp_at[s+1] && dat_at[s+1] == 8'h28, "R10 short lead recovered", fp_at[s+1], 1);
            chk(en_at[s+9] && dat_at[s+9] == 8'h81, "R10 payload aligned", dat_at[s+9], 8'h81);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule